// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block paces one cycle of a successive-approximation converter. A cycle has three timed phases: setup (stabilization), conversion and wait. The end-of-conversion interrupt is a single pulse that fires only after the wait phase has elapsed. While the conversion phase runs, the block raises an "active" strobe to the analog macro. It reports its current phase on a two-bit status output, so that a testbench or a neighbouring block can count exact phase lengths.

Raising the enable starts a 64-clock setup, and conversion follows directly. A 4-bit select code sets the conversion length. Twelve codes are legal, giving a ladder of 26-clock steps. The four codes above them are refused. After the interrupt the sequencer stays armed. Any later event restarts conversion after a fixed 3-clock trigger response, and so does an event that arrives during conversion or wait. An event is a control-register write strobe or one of the software, external or timer triggers. An event inside the setup phase reinserts the full setup, including an event on the very clock where setup would end.

Top module: `adc_tseq`

## Requirements
- R1: While reset is asserted and after it is released with enable low, `phase` is 0, and `conv_active`, `eoc_irq` and `cfg_err` are 0.
- R2: `phase` encodes 0 = idle or armed, 1 = setup (stabilization or trigger response), 2 = converting, 3 = waiting. With enable high and a legal code, the sequencer leaves idle on the next clock, shows phase 1 for exactly 64 clocks, then enters phase 2 directly.
- R3: The conversion phase lasts 26 × (code + 1) clocks for codes 0 to 11. `conv_active` is high exactly while `phase` is 2.
- R4: The wait phase lasts 8 clocks with `conv_active` low. On the first clock back at phase 0, `eoc_irq` is high for one clock only. The sequencer then stays at phase 0 until an event.
- R5: An event (`cfg_wr`, `trig_sw`, `trig_ext` or `trig_tmr` high at a clock edge) arriving in phase 2, in phase 3 or while armed is followed by 3 clocks of phase 1. A complete fresh conversion of the full length then follows.
- R6: An event during stabilization restarts the full 64-clock setup. This includes an event on the clock where setup would end, and it repeats for every such collision.
- R7: An event during the 3-clock trigger response restarts that response from its first clock.
- R8: With enable high, a code of 12 to 15 sets `cfg_err` on the next clock and holds phase 0. `cfg_err` stays set, and the block stays idle, while enable remains high, even if a legal code returns. It clears one clock after enable goes low.
- R9: Clearing enable returns `phase` to 0 and `conv_active` to 0 on the next clock. It masks `eoc_irq` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Converter enable |
| tsel | input | 4 | Conversion-length select code |
| cfg_wr | input | 1 | Pulse: a control register was written |
| trig_sw | input | 1 | Software trigger |
| trig_ext | input | 1 | External-pin trigger |
| trig_tmr | input | 1 | Timer trigger |
| phase | output | 2 | Current phase (encoding in R2) |
| conv_active | output | 1 | Strobe to the analog macro, high during conversion |
| eoc_irq | output | 1 | One-clock end-of-conversion interrupt |
| cfg_err | output | 1 | Sticky illegal-code flag |

## Verification
The bench places a register write on the precise last clock of stabilization. A design that compared against the end of setup one clock late would let that write slip through into conversion. The bench also repeats a trigger during the response latency and aborts a conversion after 100 clocks. A design that resumed the old count would show a short conversion instead of the full 312 clocks. Enable is dropped on the clock the interrupt appears, to catch an unmasked pulse. The bench also returns to a legal code after an illegal one, which exposes an error flag that is not sticky.

// File: rtl/adc_tseq_pkg.sv
package adc_tseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STAB,
    ST_LAT,
    ST_CONV,
    ST_WAIT,
    ST_ARMED
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_CONV  = 2'd2,
    PH_WAIT  = 2'd3
  } phase_t;

endpackage

// File: rtl/adc_tseq_len_dec.sv
module adc_tseq_len_dec #(
  parameter int SEL_W     = 4,
  parameter int NUM_CODES = 12,
  parameter int STEP      = 26,
  parameter int LEN_W     = 9
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [LEN_W-1:0] len_o,
  output logic             legal_o
);

  localparam int NUM_SEL = 2 ** SEL_W;
  localparam logic [SEL_W:0] CODE_LIM = (SEL_W + 1)'(NUM_CODES);

  logic [LEN_W-1:0] len_tab [NUM_SEL];

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_tab
    if (g < NUM_CODES) begin : g_legal
      assign len_tab[g] = LEN_W'((g + 1) * STEP);
    end else begin : g_prohib
      assign len_tab[g] = '0;
    end
  end

  assign len_o   = len_tab[sel_i];
  assign legal_o = ({1'b0, sel_i} < CODE_LIM);

endmodule

// File: rtl/adc_tseq_fsm.sv
module adc_tseq_fsm
  import adc_tseq_pkg::*;
#(
  parameter int STAB_CYC = 64,
  parameter int LAT_CYC  = 3,
  parameter int WAIT_CYC = 8,
  parameter int CNT_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             code_ok_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] conv_len_i,
  output seq_state_t       state_o,
  output logic             eoc_o,
  output logic             err_o
);

  localparam logic [CNT_W-1:0] STAB_LAST = CNT_W'(STAB_CYC - 1);
  localparam logic [CNT_W-1:0] LAT_LAST  = CNT_W'(LAT_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_last;
  logic             cnt_en, at_end;
  logic             eoc_q, eoc_d, err_q, err_d;

  // terminal count of the phase in progress
  always_comb begin
    case (state_q)
      ST_STAB: lim_last = STAB_LAST;
      ST_LAT:  lim_last = LAT_LAST;
      ST_CONV: lim_last = conv_len_i - CNT_W'(1);
      ST_WAIT: lim_last = WAIT_LAST;
      default: lim_last = '0;
    endcase
  end

  assign at_end = (cnt_q >= lim_last);

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    eoc_d   = 1'b0;
    err_d   = err_q;
    if (!enable_i) begin
      state_d = ST_IDLE;
      err_d   = 1'b0;
    end else if (!code_ok_i) begin
      state_d = ST_IDLE;
      err_d   = 1'b1;
    end else if (err_q) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: state_d = ST_STAB;
        ST_STAB: begin
          if (evt_i)       cnt_d = '0;
          else if (at_end) state_d = ST_CONV;
          else             cnt_d = cnt_q + CNT_W'(1);
        end
        ST_LAT: begin
          if (evt_i)       cnt_d = '0;
          else if (at_end) state_d = ST_CONV;
          else             cnt_d = cnt_q + CNT_W'(1);
        end
        ST_CONV: begin
          if (evt_i)       state_d = ST_LAT;
          else if (at_end) state_d = ST_WAIT;
          else             cnt_d = cnt_q + CNT_W'(1);
        end
        ST_WAIT: begin
          if (evt_i) begin
            state_d = ST_LAT;
          end else if (at_end) begin
            state_d = ST_ARMED;
            eoc_d   = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_ARMED: if (evt_i) state_d = ST_LAT;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      eoc_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      eoc_q   <= eoc_d;
      err_q   <= err_d;
    end
  end

  assign state_o = state_q;
  assign eoc_o   = eoc_q;
  assign err_o   = err_q;

  // R6
  stab_reinsert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STAB && evt_i && enable_i && code_ok_i && !err_q)
      |=> (state_q == ST_STAB && cnt_q == '0));

  // R7
  lat_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LAT && evt_i && enable_i && code_ok_i && !err_q)
      |=> (state_q == ST_LAT && cnt_q == '0));

  // R4
  eoc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_q |=> !eoc_q);

endmodule

// File: rtl/adc_tseq.sv
module adc_tseq
  import adc_tseq_pkg::*;
#(
  parameter int SEL_W     = 4,
  parameter int NUM_CODES = 12,
  parameter int CONV_STEP = 26,
  parameter int STAB_CYC  = 64,
  parameter int LAT_CYC   = 3,
  parameter int WAIT_CYC  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] tsel,
  input  logic             cfg_wr,
  input  logic             trig_sw,
  input  logic             trig_ext,
  input  logic             trig_tmr,
  output logic [1:0]       phase,
  output logic             conv_active,
  output logic             eoc_irq,
  output logic             cfg_err
);

  localparam int MAX_CONV = NUM_CODES * CONV_STEP;
  localparam int MAX_A    = (MAX_CONV > STAB_CYC) ? MAX_CONV : STAB_CYC;
  localparam int MAX_B    = (MAX_A > WAIT_CYC) ? MAX_A : WAIT_CYC;
  localparam int MAX_C    = (MAX_B > LAT_CYC) ? MAX_B : LAT_CYC;
  localparam int CNT_W    = $clog2(MAX_C + 1);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_n_s = rst_sync_q[1];

  logic             evt;
  logic             code_ok;
  logic [CNT_W-1:0] conv_len;
  seq_state_t       state;
  logic             eoc_raw;
  phase_t           phase_w;

  assign evt = cfg_wr | trig_sw | trig_ext | trig_tmr;

  adc_tseq_len_dec #(
    .SEL_W    (SEL_W),
    .NUM_CODES(NUM_CODES),
    .STEP     (CONV_STEP),
    .LEN_W    (CNT_W)
  ) i_len_dec (
    .sel_i  (tsel),
    .len_o  (conv_len),
    .legal_o(code_ok)
  );

  adc_tseq_fsm #(
    .STAB_CYC(STAB_CYC),
    .LAT_CYC (LAT_CYC),
    .WAIT_CYC(WAIT_CYC),
    .CNT_W   (CNT_W)
  ) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .enable_i  (enable),
    .code_ok_i (code_ok),
    .evt_i     (evt),
    .conv_len_i(conv_len),
    .state_o   (state),
    .eoc_o     (eoc_raw),
    .err_o     (cfg_err)
  );

  always_comb begin
    case (state)
      ST_STAB, ST_LAT: phase_w = PH_SETUP;
      ST_CONV:         phase_w = PH_CONV;
      ST_WAIT:         phase_w = PH_WAIT;
      default:         phase_w = PH_IDLE;
    endcase
  end

  assign phase       = phase_w;
  assign conv_active = (state == ST_CONV);
  assign eoc_irq     = eoc_raw & enable;

  // R9
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !enable |=> (phase == 2'd0 && !conv_active));

  // R8
  err_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_err && enable) |-> (phase == 2'd0));

  // R3
  conv_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(conv_active) |-> ($past(phase) == 2'd1));

  // R4
  irq_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    eoc_irq |-> ($past(phase) == 2'd3));

endmodule

// File: tb/test_adc_tseq.sv
module test_adc_tseq;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [3:0] tsel;
  logic       cfg_wr, trig_sw, trig_ext, trig_tmr;
  logic [1:0] phase;
  logic       conv_active, eoc_irq, cfg_err;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  bit done     = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_tseq i_adc_tseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tsel       (tsel),
    .cfg_wr     (cfg_wr),
    .trig_sw    (trig_sw),
    .trig_ext   (trig_ext),
    .trig_tmr   (trig_tmr),
    .phase      (phase),
    .conv_active(conv_active),
    .eoc_irq    (eoc_irq),
    .cfg_err    (cfg_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // m_mode: 0 idle, 1 stabilizing, 2 trigger response, 3 converting, 4 waiting, 5 armed
  int m_mode, m_left;
  bit m_eoc, m_err;

  always @(posedge clk or negedge rst_n) begin : model
    bit ev;
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_eoc = 0; m_err = 0;
    end else begin
      ev    = cfg_wr | trig_sw | trig_ext | trig_tmr;
      m_eoc = 0;
      if (!enable) begin
        m_mode = 0; m_err = 0;
      end else if (tsel > 11) begin
        m_mode = 0; m_err = 1;
      end else if (m_err) begin
        m_mode = 0;
      end else begin
        case (m_mode)
          0: begin m_mode = 1; m_left = 64; end
          1, 2: begin
            if (ev) m_left = (m_mode == 1) ? 64 : 3;
            else if (m_left == 1) begin m_mode = 3; m_left = 26 * (int'(tsel) + 1); end
            else m_left--;
          end
          3: begin
            if (ev) begin m_mode = 2; m_left = 3; end
            else if (m_left == 1) begin m_mode = 4; m_left = 8; end
            else m_left--;
          end
          4: begin
            if (ev) begin m_mode = 2; m_left = 3; end
            else if (m_left == 1) begin m_mode = 5; m_eoc = 1; end
            else m_left--;
          end
          default: if (ev) begin m_mode = 2; m_left = 3; end
        endcase
      end
    end
  end

  function automatic int model_phase(int md);
    case (md)
      1, 2:    return 1;
      3:       return 2;
      4:       return 3;
      default: return 0;
    endcase
  endfunction

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R2 phase vs model", phase, model_phase(m_mode));
      check("R3 conv_active vs model", conv_active, (m_mode == 3) ? 1 : 0);
      check("R4 eoc_irq vs model", eoc_irq, (m_eoc && enable) ? 1 : 0);
      check("R8 cfg_err vs model", cfg_err, m_err ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run still going after %0d cycles, expected to finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic measure(input int ph, output int n);
    n = 0;
    while (int'(phase) == ph && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    enable = 0; tsel = 0; cfg_wr = 0; trig_sw = 0; trig_ext = 0; trig_tmr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 phase in reset", phase, 0);
    check("R1 conv_active in reset", conv_active, 0);
    check("R1 eoc_irq in reset", eoc_irq, 0);
    check("R1 cfg_err in reset", cfg_err, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 phase after release", phase, 0);

    // R2 R3 R4: plain cycle, shortest code
    tsel = 0; enable = 1;
    @(negedge clk);
    measure(1, n); check("R2 stabilization length", n, 64);
    check("R2 conversion follows setup", phase, 2);
    measure(2, n); check("R3 conversion length code 0", n, 26);
    measure(3, n); check("R4 wait length", n, 8);
    check("R4 irq on return to idle", eoc_irq, 1);
    @(negedge clk);
    check("R4 irq single clock", eoc_irq, 0);
    repeat (5) @(negedge clk);
    check("R4 armed stays idle", phase, 0);

    // R5: software trigger while armed, longest code
    tsel = 11; trig_sw = 1; @(negedge clk); trig_sw = 0;
    measure(1, n); check("R5 trigger response", n, 3);
    measure(2, n); check("R3 conversion length code 11", n, 312);
    measure(3, n);

    // R5: abort mid-conversion with timer trigger
    trig_ext = 1; @(negedge clk); trig_ext = 0;
    measure(1, n);
    repeat (100) @(negedge clk);
    trig_tmr = 1; @(negedge clk); trig_tmr = 0;
    measure(1, n); check("R5 response after abort", n, 3);
    measure(2, n); check("R5 fresh full conversion", n, 312);

    // R5: register write during wait
    repeat (3) @(negedge clk);
    cfg_wr = 1; @(negedge clk); cfg_wr = 0;
    measure(1, n); check("R5 response after write in wait", n, 3);
    measure(2, n); check("R5 conversion after write", n, 312);
    measure(3, n);

    // R7: second trigger inside the response window
    trig_sw = 1; @(negedge clk); @(negedge clk); trig_sw = 0;
    measure(1, n); check("R7 response restarted", n + 1, 4);
    measure(2, n); check("R7 conversion after restart", n, 312);
    measure(3, n);

    // R6: write on the last stabilization clock
    enable = 0; @(negedge clk);
    check("R9 idle after disable", phase, 0);
    tsel = 1; enable = 1; @(negedge clk);
    repeat (63) @(negedge clk);
    check("R6 still stabilizing at last clock", phase, 1);
    cfg_wr = 1; @(negedge clk); cfg_wr = 0;
    measure(1, n); check("R6 setup reinserted", n, 64);
    measure(2, n); check("R3 conversion length code 1", n, 52);
    measure(3, n);

    // R9: disable mid-conversion
    trig_sw = 1; @(negedge clk); trig_sw = 0;
    measure(1, n);
    repeat (10) @(negedge clk);
    enable = 0; @(negedge clk);
    check("R9 phase after disable", phase, 0);
    check("R9 active after disable", conv_active, 0);

    // R9: interrupt masked by disable
    enable = 1; @(negedge clk);
    measure(1, n); measure(2, n); measure(3, n);
    check("R9 cycle completed", phase, 0);
    enable = 0; #1;
    check("R9 irq masked", eoc_irq, 0);

    // R8: prohibited code
    @(negedge clk);
    tsel = 13; enable = 1; @(negedge clk);
    check("R8 error set", cfg_err, 1);
    check("R8 held idle", phase, 0);
    tsel = 2; repeat (5) @(negedge clk);
    check("R8 error sticky", cfg_err, 1);
    check("R8 still idle with legal code", phase, 0);
    enable = 0; @(negedge clk);
    check("R8 error cleared", cfg_err, 0);
    enable = 1; @(negedge clk);
    check("R8 starts after clear", phase, 1);
    measure(1, n);
    measure(2, n); check("R3 conversion length code 2", n, 78);

    repeat (5) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule